// File: doc/BRIEF.md
# Periodic and One-Shot Countdown Timer

This block is a single down-counting event timer that advances once for every cycle in which its tick enable input is high. The tick is normally a 1 MHz strobe, so the counter measures microseconds. Software starts the timer with one write to the control word. That word carries a run bit, a mode bit that chooses periodic or one-shot operation, and a 29-bit start value. To get an interrupt after N ticks, software writes N-1. Any request of one tick or less is written as 0.

When the count is zero and a tick arrives, the timer expires. In periodic mode it reloads the start value and keeps running, so a start value of 1000000/HZ-1 gives an interrupt at HZ per second. In one-shot mode it clears its own run bit and stops. Expiry sets a pending flag that drives a level-high interrupt line. Software reads the count and the flag from a second word, the status word, and acknowledges the interrupt by writing a 1 to bit 30 of that word.

Top module: `cdt_timer`

## Requirements
- R1: After reset the timer is stopped, the interrupt output is low, the count is 0 and the read data is 0.
- R2: A write at byte offset 0x0 takes bit 31 as the run bit, bit 30 as the mode bit (1 = periodic) and bits [28:0] as the start value, which is also loaded into the count. Bit 29 is ignored. A read at offset 0x0 returns {run, mode, 0, start value}.
- R3: While running, the count goes down by one on each cycle with tick_en high. It does not change on cycles with tick_en low.
- R4: With start value N-1, expiry happens on the Nth tick after the write. A start value of 0 expires on the first tick.
- R5: In one-shot mode, expiry clears the run bit and the count stays at 0. No further expiry occurs.
- R6: In periodic mode, expiry reloads the start value and the timer keeps running, so expiries come every N ticks.
- R7: Writing 0 to offset 0x0 stops the timer. No expiry follows and the count does not change.
- R8: Expiry sets the pending flag at the clock edge that processes the expiring tick. The flag drives irq high, and irq stays high until it is cleared.
- R9: A write at offset 0x4 with bit 30 set clears the pending flag. A write at 0x4 with bit 30 clear has no effect. If a clear and an expiry happen in the same cycle, the flag stays set.
- R10: A read at offset 0x4 returns the current count in bits [28:0] and the pending flag in bit 30, with all other bits 0. Read data is registered and appears one cycle after the read strobe.
- R11: If a write to offset 0x0 and an expiry happen in the same cycle, the count, run bit and mode bit come from the write, and the pending flag is still set.
- R12: The full start value 0x1FFFFFFF is accepted and counts down from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset: 0x0 control word, 0x4 status word |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench targets the off-by-one in the N-1 convention. A timer that expires when it reaches zero, rather than on the tick after, raises irq one tick early, and a start value of 0 would then never fire. It also checks the two same-cycle collisions. If a clear beat the expiry, or if a control write swallowed the expiry, an interrupt would be lost. If the expiry beat the write, the new count would be discarded. Periodic runs are checked for a reload to the start value and not to the all-ones value, one-shot runs for staying stopped, and an acknowledge write with bit 30 clear must leave the flag alone.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int RUN_BIT  = 31;
  localparam int MODE_BIT = 30;
  localparam int ACK_BIT  = 30;
  localparam int FLAG_BIT = 30;
endpackage

// File: rtl/cdt_core.sv
module cdt_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic              run,
  output logic              periodic,
  output logic [CNT_W-1:0]  start_val,
  output logic [CNT_W-1:0]  count,
  output logic              expire
);
  import cdt_pkg::*;

  assign expire = tick_en && run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      periodic  <= 1'b0;
      start_val <= '0;
      count     <= '0;
    end else if (ld) begin
      run       <= ld_data[RUN_BIT];
      periodic  <= ld_data[MODE_BIT];
      start_val <= ld_data[CNT_W-1:0];
      count     <= ld_data[CNT_W-1:0];
    end else if (tick_en && run) begin
      if (count == '0) begin
        if (periodic) count <= start_val;
        else          run   <= 1'b0;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run && !ld && count != '0) |=> (count == $past(count) - 1'b1));
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ld) |=> $stable(count));
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic && !ld) |=> (!run && count == '0));
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic && !ld) |=> (run && count == $past(start_val)));
  a_r7_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld) |=> ($stable(count) && !run));
endmodule

// File: rtl/cdt_flag.sv
module cdt_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ack,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (ack)    pending <= 1'b0;
  end

  a_r8_set_on_expiry: assert property (@(posedge clk) disable iff (rst)
    expire |=> pending);
  a_r8_level_hold: assert property (@(posedge clk) disable iff (rst)
    (pending && !ack) |=> pending);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !expire) |=> !pending);
endmodule

// File: rtl/cdt_rdmux.sv
module cdt_rdmux #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sel_status,
  input  logic              run,
  input  logic              periodic,
  input  logic [CNT_W-1:0]  start_val,
  input  logic [CNT_W-1:0]  count,
  input  logic              pending,
  output logic [DATA_W-1:0] rd_data
);
  import cdt_pkg::*;

  logic [DATA_W-1:0] ctl_word, sts_word;

  always_comb begin
    ctl_word                = '0;
    ctl_word[CNT_W-1:0]     = start_val;
    ctl_word[RUN_BIT]       = run;
    ctl_word[MODE_BIT]      = periodic;
    sts_word                = '0;
    sts_word[CNT_W-1:0]     = count;
    sts_word[FLAG_BIT]      = pending;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_status ? sts_word : ctl_word;
  end

  a_r10_read_status: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_status) |=> (rd_data[FLAG_BIT] == $past(pending)));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import cdt_pkg::*;

  localparam int SEL_BIT = 2;

  logic             sel_status, ld, ack, expire;
  logic             run, periodic, pending;
  logic [CNT_W-1:0] start_val, count;

  assign sel_status = addr[SEL_BIT];
  assign ld         = wr_en && !sel_status;
  assign ack        = wr_en && sel_status && wr_data[ACK_BIT];

  cdt_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld(ld), .ld_data(wr_data),
    .run(run), .periodic(periodic), .start_val(start_val),
    .count(count), .expire(expire)
  );

  cdt_flag u_flag (
    .clk(clk), .rst(rst), .expire(expire), .ack(ack), .pending(pending)
  );

  cdt_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel_status(sel_status),
    .run(run), .periodic(periodic), .start_val(start_val),
    .count(count), .pending(pending), .rd_data(rd_data)
  );

  assign irq = pending;

  a_r11_write_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (ld && expire) |=> (irq && count == $past(wr_data[CNT_W-1:0])));
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    ld |=> (run == $past(wr_data[RUN_BIT]) && periodic == $past(wr_data[MODE_BIT])));
endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cdt_timer u_cdt_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    rd(3'h4, d); check("R1 status", d, 32'h0);
    rd(3'h0, d); check("R1 control", d, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(3'h0, 32'h2000_0005);
    rd(3'h0, d); check("R2 bit29 ignored", d, 32'h0000_0005);
    wr(3'h0, 32'hC000_0007);
    rd(3'h0, d); check("R2 run+mode", d, 32'hC000_0007);
    wr(3'h0, 32'h0);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    wr(3'h0, 32'h8000_0004);
    repeat (5) @(negedge clk);
    rd(3'h4, d); check("R3 no tick hold", d, 32'h4);
    ticks(3);
    rd(3'h4, d); check("R3 count after 3", d, 32'h1);
    wr(3'h0, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(3'h0, 32'h8000_0002);
    ticks(2);
    check("R4 no early irq", {31'b0, irq}, 32'h0);
    ticks(1);
    check("R4 irq on Nth tick", {31'b0, irq}, 32'h1);
    rd(3'h0, d); check("R5 run cleared", d, 32'h0000_0002);
    rd(3'h4, d); check("R10 status flag+count", d, 32'h4000_0000);
    wr(3'h4, 32'h0);
    check("R9 ack bit clear no effect", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000);
    check("R9 ack clears", {31'b0, irq}, 32'h0);
    ticks(6);
    check("R5 no refire", {31'b0, irq}, 32'h0);
    rd(3'h4, d); check("R5 count stays 0", d, 32'h0);
    wr(3'h0, 32'h8000_0000);
    ticks(1);
    check("R4 zero fires first tick", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(3'h0, 32'hC000_0003);
    ticks(4);
    check("R6 first expiry", {31'b0, irq}, 32'h1);
    rd(3'h4, d); check("R6 reloaded", d, 32'h4000_0003);
    wr(3'h4, 32'h4000_0000);
    ticks(3);
    check("R6 no early second", {31'b0, irq}, 32'h0);
    ticks(1);
    check("R6 second expiry", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000);
    wr(3'h0, 32'h0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(3'h0, 32'h8000_000A);
    ticks(3);
    wr(3'h0, 32'h0);
    ticks(15);
    check("R7 no expiry when stopped", {31'b0, irq}, 32'h0);
    rd(3'h4, d); check("R7 count held", d, 32'h0);
  endtask

  task automatic t_ack_race();
    logic [31:0] d;
    wr(3'h0, 32'h8000_0000);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 3'h4; wr_data = 32'h4000_0000;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R9 expiry beats ack", {31'b0, irq}, 32'h1);
    wr(3'h4, 32'h4000_0000);
    rd(3'h4, d); check("R9 cleared after", d, 32'h0);
  endtask

  task automatic t_write_race();
    logic [31:0] d;
    wr(3'h0, 32'h8000_0000);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 3'h0; wr_data = 32'h8000_0005;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R11 flag set", {31'b0, irq}, 32'h1);
    rd(3'h4, d); check("R11 count from write", d, 32'h4000_0005);
    rd(3'h0, d); check("R11 run from write", d, 32'h8000_0005);
    wr(3'h0, 32'h0);
    wr(3'h4, 32'h4000_0000);
  endtask

  task automatic t_max();
    logic [31:0] d;
    wr(3'h0, 32'h9FFF_FFFF);
    rd(3'h0, d); check("R12 max readback", d, 32'h9FFF_FFFF);
    ticks(3);
    rd(3'h4, d); check("R12 max countdown", d, 32'h1FFF_FFFC);
    wr(3'h0, 32'h0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_countdown();
    t_oneshot();
    t_periodic();
    t_stop();
    t_ack_race();
    t_write_race();
    t_max();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule